// File: doc/BRIEF.md
# Wormhole Mesh Router

This block is one switching node of a two-dimensional mesh network-on-chip. It has five ports: one toward each compass neighbour and one toward the local client. Every port has an input queue. Every link uses a simple push handshake: the sender raises a write strobe with a flit, and the receiver returns a full flag that blocks further writes. Packets are sequences of flits. The first flit is a header carrying the destination coordinates, any number of body flits may follow, and a tail flit closes the packet.

When a header reaches the front of an input queue, the router computes its exit port by dimension-ordered routing: X first, then Y, and the local port when both coordinates match. Inputs that want the same free exit port compete in a rotating-priority arbiter. The winner holds that exit until its tail has left. Flits are forwarded as they arrive, without waiting for the whole packet, and a packet that cannot advance stays in its input queue, where it pushes back on the upstream neighbour.

Top module: `wh_mesh_router`

## Requirements
- R1: A flit is `DATA_W+2` bits wide. Its top two bits give the kind: 01 header, 10 body, 11 tail (00 is never sent). In a header, bits [COORD_W-1:0] hold the destination X and bits [2*COORD_W-1:COORD_W] hold the destination Y.
- R2: A header is routed as follows. It goes east (port 2) if its X is greater than the node's X, and west (port 4) if it is smaller. When the X values are equal, it goes north (port 1) if its Y is greater and south (port 3) if its Y is smaller. Otherwise it goes local (port 0). Ports 0 to 4 are the bit positions in every per-port bus.
- R3: Each input queue holds 4 flits. `in_full` is high exactly when 4 flits are held, and a write presented while it is high is discarded.
- R4: A flit is written out on a port only in a cycle in which that port's `out_full` is low. Otherwise the flit waits in its input queue.
- R5: An exit port is bound to one input from the cycle its header wins until the cycle its tail is transferred. No flit of any other packet appears on that port in between.
- R6: Among inputs that keep requesting the same exit port, each is served once before any is served a second time.
- R7: Header and body flits are forwarded while the tail has not yet arrived.
- R8: The flits of each input leave in the order they were accepted. None is lost or duplicated.
- R9: After reset, `in_full` and `out_wr` are all low.
- R10: With no contention, a header written into an idle router at clock edge k is transferred on its exit port at edge k+2.
- R11: Packets from different inputs to different exit ports are forwarded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_wr | input | 5 | Per-port write strobe from the upstream neighbour |
| in_flit | input | 5 x (DATA_W+2) | Per-port incoming flit |
| in_full | output | 5 | Per-port input queue full flag toward upstream |
| out_wr | output | 5 | Per-port write strobe toward the downstream neighbour |
| out_flit | output | 5 x (DATA_W+2) | Per-port outgoing flit |
| out_full | input | 5 | Per-port full flag from the downstream neighbour |

## Verification
The bench sweeps every destination of a 4x4 grid from every input and checks the exit port of each flit. A wrong comparison in the route function would send headers to a neighbouring port or out through local. It holds a tail back while another input targets the same exit. A router that releases the exit on a header or body flit would interleave two packets there, and one that waits for the tail before forwarding would deliver nothing. It fills a queue against a blocked exit and keeps writing. An off-by-one in the full flag would accept a fifth flit, or refuse the fourth, and the accepted flits would then not match what arrives. Five inputs contending for one exit test the rotation: a fixed-priority arbiter would serve one input twice in a round.

// File: rtl/wh_router_pkg.sv
`timescale 1ns/1ps
package wh_router_pkg;
  localparam int NUM_PORTS  = 5;
  localparam int PORT_W     = 3;
  localparam int PORT_LOCAL = 0;
  localparam int PORT_NORTH = 1;
  localparam int PORT_EAST  = 2;
  localparam int PORT_SOUTH = 3;
  localparam int PORT_WEST  = 4;

  typedef enum logic [1:0] {
    FLIT_NONE = 2'b00,
    FLIT_HEAD = 2'b01,
    FLIT_BODY = 2'b10,
    FLIT_TAIL = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/router_fifo.sv
`timescale 1ns/1ps
module router_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic wr_ok, rd_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (rd_ok) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= wp_d;
      if (rd_ok) rp_q <= rp_d;
      if (wr_ok ^ rd_ok) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  AST_FIFO_FULL_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && cnt_q == $past(cnt_q))); // R3
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R8
endmodule

// File: rtl/router_rr_arb.sv
`timescale 1ns/1ps
module router_rr_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [IW-1:0] last_q, last_d;
  logic          win;

  always_comb begin
    grant  = '0;
    last_d = last_q;
    win    = 1'b0;
    for (int k = 1; k <= N; k++) begin : g_scan
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!win && req[idx]) begin
        grant[idx] = 1'b1;
        last_d     = IW'(idx);
        win        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (win) last_q <= last_d;
  end

  AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_ARB_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (win && $countones(req) > 1) |=> (last_q != $past(last_q) || !win)); // R6
endmodule

// File: rtl/wh_mesh_router.sv
`timescale 1ns/1ps
module wh_mesh_router import wh_router_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 2,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1,
  parameter int FIFO_DEPTH = 4,
  localparam int FLIT_W    = DATA_W + 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              in_wr,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0]  in_flit,
  output logic [NUM_PORTS-1:0]              in_full,
  output logic [NUM_PORTS-1:0]              out_wr,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0]  out_flit,
  input  logic [NUM_PORTS-1:0]              out_full
);
  localparam int NP = NUM_PORTS;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  function automatic logic [PORT_W-1:0] xy_route(input logic [COORD_W-1:0] dx,
                                                 input logic [COORD_W-1:0] dy);
    if (dx > COORD_W'(MY_X))      return PORT_W'(PORT_EAST);
    else if (dx < COORD_W'(MY_X)) return PORT_W'(PORT_WEST);
    else if (dy > COORD_W'(MY_Y)) return PORT_W'(PORT_NORTH);
    else if (dy < COORD_W'(MY_Y)) return PORT_W'(PORT_SOUTH);
    else                          return PORT_W'(PORT_LOCAL);
  endfunction

  logic [NP-1:0][FLIT_W-1:0] head;
  logic [NP-1:0]             fifo_empty, fifo_rd;
  logic [NP-1:0]             head_is_hdr, in_bound;
  logic [NP-1:0][PORT_W-1:0] want_port;
  logic [NP-1:0][NP-1:0]     arb_req, arb_gnt;
  logic [NP-1:0]             lock_q, lock_d, lock_en, fwd;
  logic [NP-1:0][PORT_W-1:0] owner_q, owner_d;

  for (genvar i = 0; i < NP; i++) begin : g_in
    router_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .wr_en   (in_wr[i]),
      .wr_data (in_flit[i]),
      .rd_en   (fifo_rd[i]),
      .rd_data (head[i]),
      .empty   (fifo_empty[i]),
      .full    (in_full[i])
    );
    assign head_is_hdr[i] = !fifo_empty[i] && (head[i][FLIT_W-1 -: 2] == FLIT_HEAD);
    assign want_port[i]   = xy_route(head[i][COORD_W-1:0], head[i][2*COORD_W-1:COORD_W]);
  end

  // an input already holding an exit must not request another
  always_comb begin
    in_bound = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        if (lock_q[o] && owner_q[o] == PORT_W'(i)) in_bound[i] = 1'b1;
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        arb_req[o][i] = !lock_q[o] && head_is_hdr[i] && !in_bound[i]
                        && (want_port[i] == PORT_W'(o));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    router_rr_arb #(.N(NP)) u_arb (
      .clk   (clk),
      .rst_n (rst_q_n),
      .req   (arb_req[o]),
      .grant (arb_gnt[o])
    );
    assign fwd[o]      = lock_q[o] && !fifo_empty[owner_q[o]] && !out_full[o];
    assign out_flit[o] = head[owner_q[o]];
    assign out_wr[o]   = fwd[o];

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lock_q[o] && !(out_wr[o] && out_flit[o][FLIT_W-1 -: 2] == FLIT_TAIL))
      |=> (lock_q[o] && $stable(owner_q[o]))); // R5
    AST_LOCK_ON_HEADER: assert property (@(posedge clk) disable iff (!rst_q_n)
      $rose(lock_q[o]) |-> (out_flit[o][FLIT_W-1 -: 2] == FLIT_HEAD)); // R5
    AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_q_n)
      (lock_q[o] && out_full[o]) |-> !fifo_rd[owner_q[o]]); // R4
  end

  // crossbar read side
  always_comb begin
    fifo_rd = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        if (fwd[o] && owner_q[o] == PORT_W'(i)) fifo_rd[i] = 1'b1;
  end

  // exit ownership: next state
  always_comb begin
    lock_d  = lock_q;
    owner_d = owner_q;
    lock_en = '0;
    for (int o = 0; o < NP; o++) begin
      if (!lock_q[o]) begin
        if (|arb_gnt[o]) begin
          lock_d[o]  = 1'b1;
          lock_en[o] = 1'b1;
          for (int i = 0; i < NP; i++)
            if (arb_gnt[o][i]) owner_d[o] = PORT_W'(i);
        end
      end else if (fwd[o] && out_flit[o][FLIT_W-1 -: 2] == FLIT_TAIL) begin
        lock_d[o]  = 1'b0;
        lock_en[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lock_q  <= '0;
      owner_q <= '0;
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (lock_en[o]) begin
          lock_q[o]  <= lock_d[o];
          owner_q[o] <= owner_d[o];
        end
      end
    end
  end

  AST_LOCAL_EXIT_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_wr[PORT_LOCAL] && out_flit[PORT_LOCAL][FLIT_W-1 -: 2] == FLIT_HEAD)
    |-> (out_flit[PORT_LOCAL][COORD_W-1:0] == COORD_W'(MY_X)
         && out_flit[PORT_LOCAL][2*COORD_W-1:COORD_W] == COORD_W'(MY_Y))); // R2
endmodule

// File: tb/wh_mesh_router_bench.sv
`timescale 1ns/1ps
module wh_mesh_router_bench;
  localparam int NP = 5;
  localparam int FW = 18;
  localparam int QN = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0]         in_wr, in_full, out_wr, out_full;
  logic [NP-1:0][FW-1:0] in_flit, out_flit;

  always #2.5 clk = ~clk;

  wh_mesh_router u_wh_mesh_router (
    .clk(clk), .rst_n(rst_n),
    .in_wr(in_wr), .in_flit(in_flit), .in_full(in_full),
    .out_wr(out_wr), .out_flit(out_flit), .out_full(out_full)
  );

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] sq  [NP][QN];
  logic [2:0]    sqp [NP][QN];
  int            sq_wr [NP];
  int            sq_rd [NP];
  logic [FW-1:0] eq  [NP][QN];
  logic [2:0]    eqp [NP][QN];
  int            eq_wr [NP];
  int            eq_rd [NP];
  bit            busy [NP];
  int            own  [NP];
  int            hdr_log [64];
  int            hdr_n = 0;
  int            nid = 0;
  bit            drop_mode = 1'b0;
  bit            stress = 1'b0;
  logic [NP-1:0] full_mask = '0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected exit port, node at (1,1)
  function automatic int xy(input int dx, input int dy);
    if (dx > 1) return 2;
    if (dx < 1) return 4;
    if (dy > 1) return 1;
    if (dy < 1) return 3;
    return 0;
  endfunction

  task automatic push(input int s, input logic [1:0] k, input int dx, input int dy,
                      input int port);
    sq[s][sq_wr[s] % QN]  = {k, 9'(nid), 3'(s), 2'(dy), 2'(dx)};
    sqp[s][sq_wr[s] % QN] = 3'(port);
    sq_wr[s]++;
    nid++;
  endtask

  task automatic send_pkt(input int s, input int dx, input int dy, input int nb,
                          input bit tail);
    int p = xy(dx, dy);
    push(s, 2'b01, dx, dy, p);
    for (int b = 0; b < nb; b++) push(s, 2'b10, 0, 0, p);
    if (tail) push(s, 2'b11, 0, 0, p);
  endtask

  task automatic observe(input int o);
    logic [FW-1:0] f = out_flit[o];
    int s = int'(f[6:4]);
    int k = int'(f[17:16]);
    chk(out_full[o] == 1'b0, "R4", "write while full", o, -1);
    chk(k != 0, "R1", "flit kind", k, 1);
    if (s >= NP || eq_rd[s] == eq_wr[s]) begin
      chk(1'b0, "R8", "unexpected flit id", int'(f[15:7]), -1);
    end else begin
      chk(f == eq[s][eq_rd[s] % QN], "R8", "flit id in order",
          int'(f[15:7]), int'(eq[s][eq_rd[s] % QN][15:7]));
      chk(o == int'(eqp[s][eq_rd[s] % QN]), "R2", "exit port", o,
          int'(eqp[s][eq_rd[s] % QN]));
      eq_rd[s]++;
    end
    if (k == 1) begin
      chk(!busy[o], "R5", "header inside open packet", o, -1);
      busy[o] = 1'b1;
      own[o]  = s;
      if (o == 0 && hdr_n < 64) begin
        hdr_log[hdr_n] = s;
        hdr_n++;
      end
    end else begin
      chk(busy[o] && own[o] == s, "R5", "interleaved source", s, own[o]);
      if (k == 3) busy[o] = 1'b0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (sq_rd[p] != sq_wr[p]) begin
        in_wr[p]   = 1'b1;
        in_flit[p] = sq[p][sq_rd[p] % QN];
        if (!in_full[p]) begin
          eq[p][eq_wr[p] % QN]  = in_flit[p];
          eqp[p][eq_wr[p] % QN] = sqp[p][sq_rd[p] % QN];
          eq_wr[p]++;
          sq_rd[p]++;
        end else if (drop_mode) begin
          sq_rd[p]++;
        end
      end else begin
        in_wr[p]   = 1'b0;
        in_flit[p] = '0;
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_full = full_mask | (stress ? (lfsr[4:0] & lfsr[9:5]) : 5'b0);
    #1;
    for (int o = 0; o < NP; o++) if (out_wr[o]) observe(o);
  endtask

  function automatic bit all_done();
    for (int p = 0; p < NP; p++)
      if (sq_rd[p] != sq_wr[p] || eq_rd[p] != eq_wr[p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain(input int maxc);
    int n = 0;
    while (!all_done() && n < maxc) begin
      step();
      n++;
    end
    chk(all_done(), "R8", "all flits delivered", n, maxc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      sq_wr[p] = 0; sq_rd[p] = 0; eq_wr[p] = 0; eq_rd[p] = 0;
      busy[p] = 1'b0; own[p] = 0;
    end
    in_wr = '0;
    in_flit = '0;
    out_full = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_full == '0, "R9", "in_full in reset", int'(in_full), 0);
    chk(out_wr == '0, "R9", "out_wr in reset", int'(out_wr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_full == '0, "R9", "in_full after reset", int'(in_full), 0);
    chk(out_wr == '0, "R9", "out_wr after reset", int'(out_wr), 0);

    // zero-load latency and parallel exits
    send_pkt(0, 2, 1, 0, 1'b1);
    send_pkt(4, 1, 2, 0, 1'b1);
    step();
    chk(out_wr == '0, "R10", "out_wr one cycle after write", int'(out_wr), 0);
    step();
    chk(out_wr == '0, "R10", "out_wr during arbitration", int'(out_wr), 0);
    step();
    chk(out_wr[2] == 1'b1, "R10", "header on east at k+2", int'(out_wr[2]), 1);
    chk(out_wr[1] == 1'b1, "R11", "second exit in same cycle", int'(out_wr[1]), 1);
    drain(50);

    // full routing sweep from every input
    for (int s = 0; s < NP; s++)
      for (int dx = 0; dx < 4; dx++)
        for (int dy = 0; dy < 4; dy++)
          send_pkt(s, dx, dy, 1, 1'b1);
    drain(2000);

    // wormhole: tail withheld, exit stays bound
    send_pkt(1, 1, 1, 2, 1'b0);
    repeat (6) step();
    chk(eq_rd[1] == eq_wr[1] && sq_rd[1] == sq_wr[1], "R7",
        "header and bodies forwarded before tail", eq_wr[1] - eq_rd[1], 0);
    send_pkt(3, 1, 1, 1, 1'b1);
    repeat (8) step();
    chk(eq_wr[3] - eq_rd[3] == 3, "R5", "other packet held off bound exit",
        eq_wr[3] - eq_rd[3], 3);
    chk(out_wr[0] == 1'b0, "R5", "bound exit idle without owner flits",
        int'(out_wr[0]), 0);
    push(1, 2'b11, 0, 0, 0);
    drain(50);

    // rotating priority among five contenders
    hdr_n = 0;
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < NP; s++) send_pkt(s, 1, 1, 1, 1'b1);
    drain(200);
    for (int r = 0; r < 2; r++) begin
      logic [NP-1:0] seen = '0;
      for (int j = 0; j < NP; j++) seen[hdr_log[r * NP + j]] = 1'b1;
      chk(seen == 5'b11111, "R6", "each input once per round", int'(seen), 31);
    end

    // queue fill against a blocked exit, extra writes discarded
    full_mask = 5'b00001;
    drop_mode = 1'b1;
    send_pkt(2, 1, 1, 2, 1'b1);
    push(2, 2'b10, 0, 0, 0);
    push(2, 2'b10, 0, 0, 0);
    repeat (4) step();
    chk(in_full[2] == 1'b0, "R3", "not full with three held", int'(in_full[2]), 0);
    step();
    chk(in_full[2] == 1'b1, "R3", "full with four held", int'(in_full[2]), 1);
    step();
    step();
    chk(eq_wr[2] - eq_rd[2] == 4, "R3", "accepted count", eq_wr[2] - eq_rd[2], 4);
    chk(out_wr[0] == 1'b0, "R4", "blocked exit silent", int'(out_wr[0]), 0);
    full_mask = '0;
    drop_mode = 1'b0;
    drain(50);
    chk(in_full[2] == 1'b0, "R3", "full clears after drain", int'(in_full[2]), 0);

    // random backpressure on every exit
    stress = 1'b1;
    for (int k = 0; k < 8; k++)
      for (int s = 0; s < NP; s++)
        send_pkt(s, (s * 3 + k) % 4, (s + k * 3) % 4, k % 4, 1'b1);
    drain(20000);
    stress = 1'b0;
    for (int o = 0; o < NP; o++)
      chk(!busy[o], "R5", "exit released after tail", o, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule